// File: doc/BRIEF.md
# Configurable Programmable-Logic Output Cell Register

This block is one output cell of a sum-of-products programmable device. It holds a single storage bit that static configuration inputs turn into a combinational bypass, a D flip-flop, a toggle flip-flop, a transparent latch or a flop that captures on both clock edges. The data bit comes either from the product-term sum or directly from an input pin. The clock comes from one of three global clocks or a product-term clock, with a selectable polarity. A product-term clock enable gates capture. Local product-term set and reset inputs and a global set/reset line override the clock.

All clock-source inputs are sampled by the single system clock `clk`. A rising or falling edge of the effective (polarity-adjusted) source is detected between two consecutive samples, and the storage bit is updated at the system edge where the change is seen. Set and reset act on the output at once, without waiting for a clock edge. They are also written into the storage bit, so the forced value remains after they are released. All pins are plain level signals. The cell carries no data stream, so it has no valid/ready handshake and no back-pressure. The power-up value is loaded while `rst_n` is low.

Top module: `macrocell_reg`

## Requirements
- R1: With `cfg_comb`=1, `q` equals the selected data bit in the same cycle, whatever the set, reset and clock inputs do.
- R2: The data bit is `pin_in` when `cfg_src_pin`=1 and `sop_in` when it is 0.
- R3: `cfg_clk_sel` values 0, 1 and 2 select `gclk[0]`, `gclk[1]` and `gclk[2]`. Value 3 selects `pt_clk`. `cfg_clk_inv`=1 inverts the selected source before edge detection and level use.
- R4: A rising (falling) edge is seen at a `clk` edge when the effective source is 1 (0) there and was 0 (1) at the previous `clk` edge. The sample before the first edge after reset counts as 0. A registered update is visible on `q` after that `clk` edge.
- R5: `cfg_type`=0 (and the unused code 3) is a D flop: at a rising edge with `pt_ce`=1, the data bit is stored.
- R6: `cfg_type`=1 is a toggle flop: at a rising edge with `pt_ce`=1, the stored bit inverts when the data bit is 1 and holds when it is 0.
- R7: With `pt_ce`=0 and no set or reset active, the stored bit never changes.
- R8: `cfg_type`=2 is a latch: while the effective source is 1 and `pt_ce`=1, `q` follows the data bit combinationally. Otherwise `q` holds the last value passed.
- R9: With `cfg_dual`=1 the D and toggle flops also update at falling edges, under the same rules as at rising edges.
- R10: While `rst_n`=0 the stored bit equals `cfg_init`.
- R11: With `cfg_gsr_en`=1, `gsr`=1 acts as set when `cfg_gsr_set`=1 and as reset when it is 0. With `cfg_gsr_en`=0, `gsr` has no effect.
- R12: `pt_rst` forces `q` to 0 and `pt_set` forces it to 1 in the same cycle. Reset wins over set, and both override `pt_ce` and clock edges. The stored bit takes the forced value at that `clk` edge and keeps it after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset; loads the power-up value |
| sop_in | input | 1 | Sum-of-products data bit |
| pin_in | input | 1 | Direct input-pin data bit |
| gclk | input | N_GCLK | Global clock sources |
| pt_clk | input | 1 | Product-term clock source |
| pt_ce | input | 1 | Product-term clock enable |
| pt_set | input | 1 | Local set term |
| pt_rst | input | 1 | Local reset term |
| gsr | input | 1 | Global set/reset line |
| cfg_comb | input | 1 | 1 = combinational output |
| cfg_src_pin | input | 1 | 1 = data from pin |
| cfg_type | input | 2 | 0 D, 1 toggle, 2 latch, 3 as D |
| cfg_clk_sel | input | CSEL_W | Clock source select |
| cfg_clk_inv | input | 1 | Invert selected clock |
| cfg_dual | input | 1 | Capture on both edges |
| cfg_init | input | 1 | Power-up value |
| cfg_gsr_en | input | 1 | Cell responds to `gsr` |
| cfg_gsr_set | input | 1 | `gsr` sets (1) or clears (0) |
| q | output | 1 | Cell output |

## Verification
The assertions check four things on every cycle: edge detection never reports two rising edges in a row, every write request lands in the two-register storage with the requested value, the stored bit is frozen when the enable is low and no force is active, and a local set or reset shows on the output at once and stays in the stored bit. The data values that each mode produces come only from the bench's scenarios: the toggle and latch behaviour, capture on the falling edge in dual mode, the source and polarity multiplexing, and response to the global line or its absence. In these scenarios a behavioural model is compared with `q` on every cycle.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;
  typedef enum logic [1:0] {
    MC_KIND_D     = 2'd0,
    MC_KIND_T     = 2'd1,
    MC_KIND_LATCH = 2'd2,
    MC_KIND_SPARE = 2'd3
  } mc_kind_e;
endpackage

// File: rtl/mc_clk_edge.sv
// Selects one clock source, applies polarity, and detects edges of it
// against the previous system-clock sample.
module mc_clk_edge #(
  parameter int N_GCLK = 3,
  parameter int CSEL_W = $clog2(N_GCLK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GCLK-1:0] gclk,
  input  logic              pt_clk,
  input  logic [CSEL_W-1:0] sel,
  input  logic              inv,
  output logic              lvl,
  output logic              rise,
  output logic              fall
);
  logic raw;
  logic prev_q;

  always_comb begin
    raw = pt_clk;
    for (int i = 0; i < N_GCLK; i++) begin
      if (sel == CSEL_W'(i)) raw = gclk[i];
    end
  end

  assign lvl  = raw ^ inv;
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  AST_NO_DOUBLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R4
endmodule

// File: rtl/mc_force.sv
// Merges local and global set/reset terms; reset has priority.
module mc_force (
  input  logic pt_set,
  input  logic pt_rst,
  input  logic gsr,
  input  logic gsr_en,
  input  logic gsr_set,
  output logic force_set,
  output logic force_clr
);
  logic gsr_live;
  assign gsr_live  = gsr & gsr_en;
  assign force_clr = pt_rst | (gsr_live & ~gsr_set);
  assign force_set = ~force_clr & (pt_set | (gsr_live & gsr_set));
endmodule

// File: rtl/mc_cell_store.sv
// Storage bit built from a rise-side and fall-side register whose XOR is
// the stored value; a write to either side never glitches the other.
module mc_cell_store #(
  parameter bit DUAL_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic wr_en,
  input  logic wr_on_fall,
  input  logic wr_val,
  output logic stored
);
  logic qr;
  logic qf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    qr <= init;
    else if (wr_en && !wr_on_fall) qr <= wr_val ^ qf;
  end

  generate
    if (DUAL_EN) begin : g_fall_side
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   qf <= 1'b0;
        else if (wr_en && wr_on_fall) qf <= wr_val ^ qr;
      end
    end else begin : g_no_fall_side
      assign qf = 1'b0;
    end
  endgenerate

  assign stored = qr ^ qf;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (stored == $past(wr_val))); // R9
endmodule

// File: rtl/macrocell_reg.sv
module macrocell_reg
  import macrocell_pkg::*;
#(
  parameter int N_GCLK  = 3,
  parameter bit DUAL_EN = 1'b1,
  parameter int CSEL_W  = $clog2(N_GCLK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sop_in,
  input  logic              pin_in,
  input  logic [N_GCLK-1:0] gclk,
  input  logic              pt_clk,
  input  logic              pt_ce,
  input  logic              pt_set,
  input  logic              pt_rst,
  input  logic              gsr,
  input  logic              cfg_comb,
  input  logic              cfg_src_pin,
  input  logic [1:0]        cfg_type,
  input  logic [CSEL_W-1:0] cfg_clk_sel,
  input  logic              cfg_clk_inv,
  input  logic              cfg_dual,
  input  logic              cfg_init,
  input  logic              cfg_gsr_en,
  input  logic              cfg_gsr_set,
  output logic              q
);
  mc_kind_e kind;
  logic d_sel, lvl, rise, fall;
  logic force_set, force_clr;
  logic is_latch, is_t, dual_on;
  logic transparent, edge_hit, cap_val;
  logic wr_en, wr_on_fall, wr_val, stored;

  assign kind  = mc_kind_e'(cfg_type);
  assign d_sel = cfg_src_pin ? pin_in : sop_in;

  mc_clk_edge #(.N_GCLK(N_GCLK), .CSEL_W(CSEL_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .gclk(gclk), .pt_clk(pt_clk),
    .sel(cfg_clk_sel), .inv(cfg_clk_inv),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  mc_force u_force (
    .pt_set(pt_set), .pt_rst(pt_rst), .gsr(gsr),
    .gsr_en(cfg_gsr_en), .gsr_set(cfg_gsr_set),
    .force_set(force_set), .force_clr(force_clr)
  );

  assign is_latch    = (kind == MC_KIND_LATCH);
  assign is_t        = (kind == MC_KIND_T);
  assign dual_on     = DUAL_EN & cfg_dual;
  assign transparent = is_latch & lvl & pt_ce;
  assign edge_hit    = ~is_latch & pt_ce & (rise | (dual_on & fall));
  assign cap_val     = is_t ? (stored ^ d_sel) : d_sel;

  assign wr_en      = force_clr | force_set | transparent | edge_hit;
  assign wr_on_fall = ~force_clr & ~force_set & edge_hit & dual_on & fall;
  assign wr_val     = force_clr ? 1'b0 : (force_set ? 1'b1 : cap_val);

  mc_cell_store #(.DUAL_EN(DUAL_EN)) u_store (
    .clk(clk), .rst_n(rst_n), .init(cfg_init),
    .wr_en(wr_en), .wr_on_fall(wr_on_fall), .wr_val(wr_val),
    .stored(stored)
  );

  always_comb begin
    if (cfg_comb)         q = d_sel;
    else if (force_clr)   q = 1'b0;
    else if (force_set)   q = 1'b1;
    else if (transparent) q = d_sel;
    else                  q = stored;
  end

  AST_CLR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rst |=> (stored == 1'b0)); // R12
  AST_SET_FORCES_Q: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_comb && pt_set && !force_clr) |-> q); // R12
  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pt_ce && !force_set && !force_clr) |=> (stored == $past(stored))); // R7
endmodule

// File: tb/macrocell_reg_test.sv
module macrocell_reg_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sop_in, pin_in, pt_clk, pt_ce, pt_set, pt_rst, gsr;
  logic [2:0] gclk;
  logic cfg_comb, cfg_src_pin, cfg_clk_inv, cfg_dual, cfg_init, cfg_gsr_en, cfg_gsr_set;
  logic [1:0] cfg_type, cfg_clk_sel;
  logic q;

  int n_tests = 0;
  int n_fail  = 0;
  int m_prev  = 0;
  int m_stored = 0;
  bit done = 0;

  macrocell_reg uut (
    .clk(clk), .rst_n(rst_n), .sop_in(sop_in), .pin_in(pin_in), .gclk(gclk),
    .pt_clk(pt_clk), .pt_ce(pt_ce), .pt_set(pt_set), .pt_rst(pt_rst), .gsr(gsr),
    .cfg_comb(cfg_comb), .cfg_src_pin(cfg_src_pin), .cfg_type(cfg_type),
    .cfg_clk_sel(cfg_clk_sel), .cfg_clk_inv(cfg_clk_inv), .cfg_dual(cfg_dual),
    .cfg_init(cfg_init), .cfg_gsr_en(cfg_gsr_en), .cfg_gsr_set(cfg_gsr_set), .q(q)
  );

  task automatic check(string tag, logic act, int expv);
    n_tests++;
    if (act !== 1'(expv)) begin
      n_fail++;
      $display("FAIL %s: q=%0b expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  // One cycle: inputs are already applied at the falling edge.
  task automatic step(string tag);
    int d, src, eff, rise, fall, clr, st, nxt, expq;
    #1;
    d    = cfg_src_pin ? int'(pin_in) : int'(sop_in);
    src  = (cfg_clk_sel == 2'd3) ? int'(pt_clk) : int'(gclk[cfg_clk_sel]);
    eff  = cfg_clk_inv ? 1 - src : src;
    rise = (eff == 1 && m_prev == 0);
    fall = (eff == 0 && m_prev == 1);
    clr  = pt_rst || (gsr && cfg_gsr_en && !cfg_gsr_set);
    st   = pt_set || (gsr && cfg_gsr_en && cfg_gsr_set);
    nxt  = m_stored;
    if (clr) nxt = 0;
    else if (st) nxt = 1;
    else if (cfg_type == 2'd2) begin
      if (eff == 1 && pt_ce) nxt = d;
    end else if ((rise || (cfg_dual && fall)) && pt_ce) begin
      nxt = (cfg_type == 2'd1) ? (m_stored + d) % 2 : d;
    end
    if (cfg_comb) expq = d;
    else if (clr) expq = 0;
    else if (st)  expq = 1;
    else if (cfg_type == 2'd2 && eff == 1 && pt_ce) expq = d;
    else expq = m_stored;
    check(tag, q, expq);
    m_stored = nxt;
    m_prev   = eff;
    @(negedge clk);
  endtask

  task automatic rand_cycles(string tag, int n, bit use_force, bit use_gsr, int ce_mode);
    for (int k = 0; k < n; k++) begin
      sop_in = 1'($urandom); pin_in = 1'($urandom);
      gclk   = 3'($urandom); pt_clk = 1'($urandom);
      pt_ce  = (ce_mode == 0) ? 1'b0 : (ce_mode == 1) ? 1'b1 : 1'(($urandom % 4) != 0);
      pt_set = use_force ? 1'(($urandom % 4) == 0) : 1'b0;
      pt_rst = use_force ? 1'(($urandom % 4) == 0) : 1'b0;
      gsr    = use_gsr   ? 1'(($urandom % 3) == 0) : 1'b0;
      step(tag);
    end
  endtask

  task automatic set_cfg(logic comb, logic srcp, logic [1:0] typ, logic [1:0] csel,
                         logic inv, logic dual);
    cfg_comb = comb; cfg_src_pin = srcp; cfg_type = typ;
    cfg_clk_sel = csel; cfg_clk_inv = inv; cfg_dual = dual;
  endtask

  task automatic do_reset(logic init);
    rst_n = 1'b0; cfg_init = init;
    gclk = '0; pt_clk = 0; pt_ce = 0; pt_set = 0; pt_rst = 0; gsr = 0;
    m_stored = init; m_prev = 0;
    repeat (2) @(negedge clk);
    #1 check("R10", q, init);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive1(logic g0, logic d, logic ce, logic s, logic r);
    gclk = {2'b00, g0}; pt_clk = 0; sop_in = d; pin_in = ~d;
    pt_ce = ce; pt_set = s; pt_rst = r; gsr = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sop_in = 0; pin_in = 0;
    cfg_gsr_en = 0; cfg_gsr_set = 0;
    set_cfg(0, 0, 2'd0, 2'd0, 0, 0);
    @(negedge clk);
    do_reset(1'b1);                                     // R10 power-up 1

    set_cfg(1, 0, 2'd0, 2'd0, 0, 0); rand_cycles("R1", 40, 1, 0, 2);
    set_cfg(1, 1, 2'd1, 2'd3, 1, 1); rand_cycles("R1", 20, 1, 0, 2);
    set_cfg(0, 0, 2'd0, 2'd0, 0, 0); rand_cycles("R5", 60, 0, 0, 2);
    set_cfg(0, 0, 2'd3, 2'd0, 0, 0); rand_cycles("R5", 30, 0, 0, 2);
    set_cfg(0, 1, 2'd0, 2'd0, 0, 0); rand_cycles("R2", 50, 0, 0, 2);
    for (int s = 1; s < 4; s++) begin
      set_cfg(0, 0, 2'd0, 2'(s), 0, 0); rand_cycles("R3", 30, 0, 0, 1);
      set_cfg(0, 0, 2'd0, 2'(s), 1, 0); rand_cycles("R3", 30, 0, 0, 1);
    end

    // R4 directed: rise seen only where level goes 0 -> 1
    set_cfg(0, 0, 2'd0, 2'd0, 0, 0);
    drive1(0, 1, 1, 0, 0); step("R4");
    drive1(1, 1, 1, 0, 0); step("R4");                  // capture 1 here
    drive1(1, 0, 1, 0, 0); step("R4");                  // level high, no edge
    check("R4", q, 1);
    drive1(0, 0, 1, 0, 0); step("R4");
    drive1(1, 0, 1, 0, 0); step("R4");
    #1 check("R4", q, 0);
    @(negedge clk);

    set_cfg(0, 0, 2'd1, 2'd0, 0, 0); rand_cycles("R6", 60, 0, 0, 2);
    set_cfg(0, 0, 2'd2, 2'd0, 0, 0); rand_cycles("R8", 50, 0, 0, 2);
    set_cfg(0, 1, 2'd2, 2'd3, 1, 0); rand_cycles("R8", 40, 0, 0, 2);

    // R9 directed: falling edge capture in dual mode
    set_cfg(0, 0, 2'd0, 2'd0, 0, 1);
    drive1(0, 0, 1, 0, 0); step("R9");
    drive1(1, 1, 1, 0, 0); step("R9");                  // rise stores 1
    drive1(0, 0, 1, 0, 0); step("R9");                  // fall stores 0
    #1 check("R9", q, 0);
    @(negedge clk);
    rand_cycles("R9", 60, 0, 0, 2);
    set_cfg(0, 0, 2'd1, 2'd2, 1, 1); rand_cycles("R9", 60, 0, 0, 2);

    set_cfg(0, 0, 2'd0, 2'd0, 0, 0); rand_cycles("R7", 40, 0, 0, 0);
    set_cfg(0, 0, 2'd2, 2'd0, 0, 1); rand_cycles("R7", 30, 0, 0, 0);

    set_cfg(0, 0, 2'd0, 2'd0, 0, 1);
    cfg_gsr_en = 1; cfg_gsr_set = 1; rand_cycles("R11", 40, 0, 1, 2);
    cfg_gsr_en = 1; cfg_gsr_set = 0; rand_cycles("R11", 40, 0, 1, 2);
    cfg_gsr_en = 0; cfg_gsr_set = 1; rand_cycles("R11", 40, 0, 1, 2);
    cfg_gsr_en = 0;

    // R12 directed: both asserted, reset wins over enable and edge
    set_cfg(0, 0, 2'd0, 2'd0, 0, 0);
    drive1(0, 1, 1, 1, 1); step("R12");
    drive1(1, 1, 1, 1, 1); step("R12");
    drive1(1, 1, 1, 0, 0); step("R12");                 // stays 0 after release
    #1 check("R12", q, 0);
    @(negedge clk);
    drive1(0, 0, 0, 1, 0); step("R12");                 // set with ce low
    drive1(0, 0, 0, 0, 0); step("R12");
    set_cfg(0, 0, 2'd0, 2'd0, 0, 0); rand_cycles("R12", 50, 1, 0, 2);
    set_cfg(0, 1, 2'd2, 2'd1, 0, 0); rand_cycles("R12", 40, 1, 0, 2);
    set_cfg(0, 0, 2'd1, 2'd0, 1, 1); rand_cycles("R12", 40, 1, 0, 2);

    set_cfg(0, 0, 2'd0, 2'd0, 0, 0);
    do_reset(1'b0);                                     // R10 power-up 0
    rand_cycles("R10", 10, 0, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule